// File: doc/BRIEF.md
# Banked Interrupt Mask Controller

This block collects 96 level-sensitive interrupt lines into three banks of 32 and keeps an enable mask for each bank. Software never rewrites a mask as a whole. Each bank has one address that sets enable bits and another that clears them. A 1 in the written word acts on that bit, and a 0 leaves it alone, so software never has to read, modify and write a mask.

Each bank's pending word is its raw inputs ANDed with its enables. A single level output `irq_o` rises when any pending bit is set. A driver masks every source by writing all ones to the three clear addresses. It unmasks the sources it owns through the set addresses, and it polls the pending words to find which source fired.

The register port is a plain 32-bit port with a byte address; the two low address bits are ignored. Reads have one cycle of latency. A spare 32-bit scratch word is kept at its own address. It has no effect on the interrupt logic.

Top module: `bank_irq_ctrl`

## Requirements
- R1: While `rst_ni` is low, all 96 enables, the scratch word, `rd_data_o` and `irq_o` are 0.
- R2: Reads of byte addresses 0x00, 0x04 and 0x08 return the pending word of bank 0, 1 and 2. A pending word is that bank's slice of `irq_src_i` (bank b = bits 32b+31..32b) ANDed with its enable mask.
- R3: A write to the set address of a bank (0x18 for bank 0, 0x10 for bank 1, 0x14 for bank 2) sets each enable whose data bit is 1 and leaves the others unchanged.
- R4: A write to the clear address of a bank (0x24 for bank 0, 0x1C for bank 1, 0x20 for bank 2) clears each enable whose data bit is 1 and leaves the others unchanged.
- R5: A read of either the set address or the clear address of a bank returns that bank's current enable mask.
- R6: Writes to the pending addresses 0x00, 0x04 and 0x08 change no enable.
- R7: Address 0x0C holds a 32-bit scratch word that reads back what was last written to it. Writing it changes no enable and does not change `irq_o`.
- R8: `irq_o` is the OR of all 96 pending bits, delayed by one register: its value after a clock edge is the OR of the pending bits just before that edge.
- R9: `rd_data_o` is loaded at the clock edge where `rd_en_i` is high and holds its value otherwise. Reads of word addresses above 0x24 return 0, and writes to them change nothing.
- R10: After all ones are written to the three clear addresses, every pending word reads 0 and `irq_o` is low, whatever `irq_src_i` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte address; bits 1:0 ignored |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Read data, valid the cycle after `rd_en_i` |
| irq_src_i | input | 96 | Level interrupt inputs, bank b in bits 32b+31..32b |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The properties assume that `irq_src_i`, `addr_i`, `wr_en_i` and `wr_data_i` are known (not X) at every rising edge, because `irq_o` is checked against the sampled AND of those inputs with the masks. They also assume that one port access decodes to at most one register. The bench changes every input only on the falling edge, and it drives the interrupt lines from a fully defined random word. Random addresses cover all ten mapped words, the unmapped range and random low address bits.

// File: rtl/bic_pkg.sv
package bic_pkg;
  localparam int NUM_BANKS = 3;
  localparam int DATA_W    = 32;
  localparam int MAP_WORDS = 10;

  // word index of each register; bank order of set/clear is part of the map
  function automatic int pend_word(input int b);
    return b;
  endfunction

  function automatic int set_word(input int b);
    return (b == 0) ? 6 : 3 + b;
  endfunction

  function automatic int clr_word(input int b);
    return (b == 0) ? 9 : 6 + b;
  endfunction

  localparam int SPARE_WORD = 3;

  typedef struct packed {
    logic [NUM_BANKS-1:0] pend_sel;
    logic [NUM_BANKS-1:0] set_sel;
    logic [NUM_BANKS-1:0] clr_sel;
    logic                 spare_sel;
  } sel_t;
endpackage

// File: rtl/bic_addr_dec.sv
module bic_addr_dec
  import bic_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output sel_t              sel_o
);
  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] widx;
  assign widx = addr_i[ADDR_W-1:2];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign sel_o.pend_sel[b] = (widx == WIDX_W'(pend_word(b)));
    assign sel_o.set_sel[b]  = (widx == WIDX_W'(set_word(b)));
    assign sel_o.clr_sel[b]  = (widx == WIDX_W'(clr_word(b)));
  end

  assign sel_o.spare_sel = (widx == WIDX_W'(SPARE_WORD));
endmodule

// File: rtl/bic_mask_bank.sv
module bic_mask_bank #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_stb_i,
  input  logic         clr_stb_i,
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] src_i,
  output logic [W-1:0] en_o,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] en_q, en_d, set_v, clr_v;

  assign set_v = set_stb_i ? data_i : '0;
  assign clr_v = clr_stb_i ? data_i : '0;
  // clear wins over set on the same bit
  assign en_d  = (en_q | set_v) & ~clr_v;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else         en_q <= en_d;
  end

  assign en_o   = en_q;
  assign pend_o = src_i & en_q;
endmodule

// File: rtl/bic_rd_mux.sv
module bic_rd_mux
  import bic_pkg::*;
#(
  parameter int W = 32
) (
  input  sel_t                        sel_i,
  input  logic [NUM_BANKS-1:0][W-1:0] en_i,
  input  logic [NUM_BANKS-1:0][W-1:0] pend_i,
  input  logic [W-1:0]                spare_i,
  output logic [W-1:0]                word_o
);
  always_comb begin
    word_o = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (sel_i.pend_sel[b])                    word_o = word_o | pend_i[b];
      if (sel_i.set_sel[b] || sel_i.clr_sel[b]) word_o = word_o | en_i[b];
    end
    if (sel_i.spare_sel) word_o = word_o | spare_i;
  end
endmodule

// File: rtl/bank_irq_ctrl.sv
module bank_irq_ctrl
  import bic_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic                          wr_en_i,
  input  logic [DATA_W-1:0]             wr_data_i,
  input  logic                          rd_en_i,
  output logic [DATA_W-1:0]             rd_data_o,
  input  logic [NUM_BANKS*DATA_W-1:0]   irq_src_i,
  output logic                          irq_o
);
  sel_t                             sel;
  logic [NUM_BANKS-1:0][DATA_W-1:0] en, pend;
  logic [DATA_W-1:0]                spare_q, rd_word, rd_q;
  logic                             irq_q;

  bic_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bic_mask_bank #(.W(DATA_W)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .set_stb_i (wr_en_i & sel.set_sel[b]),
      .clr_stb_i (wr_en_i & sel.clr_sel[b]),
      .data_i    (wr_data_i),
      .src_i     (irq_src_i[b*DATA_W +: DATA_W]),
      .en_o      (en[b]),
      .pend_o    (pend[b])
    );
  end

  bic_rd_mux #(.W(DATA_W)) u_mux (
    .sel_i   (sel),
    .en_i    (en),
    .pend_i  (pend),
    .spare_i (spare_q),
    .word_o  (rd_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      spare_q <= '0;
      rd_q    <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (wr_en_i && sel.spare_sel) spare_q <= wr_data_i;
      if (rd_en_i)                  rd_q    <= rd_word;
      irq_q <= |pend;
    end
  end

  assign rd_data_o = rd_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/bic_chk.sv
module bic_chk
  import bic_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [ADDR_W-1:0]             addr_i,
  input logic                          wr_en_i,
  input logic [DATA_W-1:0]             wr_data_i,
  input logic                          rd_en_i,
  input logic [DATA_W-1:0]             rd_data_o,
  input logic                          irq_o,
  input logic [NUM_BANKS*DATA_W-1:0]   en_flat,
  input logic [NUM_BANKS*DATA_W-1:0]   pend_flat
);
  logic [ADDR_W-3:0] widx;
  logic              no_mask_wr;
  assign widx       = addr_i[ADDR_W-1:2];
  assign no_mask_wr = !wr_en_i || widx <= (ADDR_W-2)'(3) || widx >= (ADDR_W-2)'(MAP_WORDS);

  // R8
  irq_follows_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> irq_o == |$past(pend_flat));

  // R3
  set_bank0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && widx == (ADDR_W-2)'(6)) |=>
      ((en_flat[DATA_W-1:0] & $past(wr_data_i)) == $past(wr_data_i)));

  // R4
  clr_bank1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && widx == (ADDR_W-2)'(7)) |=>
      ((en_flat[2*DATA_W-1:DATA_W] & $past(wr_data_i)) == '0));

  // R6
  mask_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_mask_wr |=> $stable(en_flat));

  // R9
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

bind bank_irq_ctrl bic_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .rd_en_i   (rd_en_i),
  .rd_data_o (rd_data_o),
  .irq_o     (irq_o),
  .en_flat   (en),
  .pend_flat (pend)
);

// File: tb/bank_irq_ctrl_bench.sv
module bank_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [95:0] src = '0;
  logic        irq;

  int n_tests = 0, n_fail = 0;
  logic [31:0] en_m [3];
  logic [31:0] spare_m;
  bit done = 0;

  always #2 clk = ~clk;

  bank_irq_ctrl u_bank_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(we), .wr_data_i(wdata),
    .rd_en_i(re), .rd_data_o(rdata), .irq_src_i(src), .irq_o(irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pend_m(input int b);
    return src[b*32 +: 32] & en_m[b];
  endfunction

  function automatic logic exp_irq();
    return |{pend_m(0), pend_m(1), pend_m(2)};
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a[7:2])
      6'd0, 6'd1, 6'd2: return pend_m(int'(a[7:2]));
      6'd3:             return spare_m;
      6'd4, 6'd7:       return en_m[1];
      6'd5, 6'd8:       return en_m[2];
      6'd6, 6'd9:       return en_m[0];
      default:          return '0;
    endcase
  endfunction

  function automatic void model_write(input logic [7:0] a, input logic [31:0] d);
    case (a[7:2])
      6'd3: spare_m = d;
      6'd4: en_m[1] |= d;
      6'd5: en_m[2] |= d;
      6'd6: en_m[0] |= d;
      6'd7: en_m[1] &= ~d;
      6'd8: en_m[2] &= ~d;
      6'd9: en_m[0] &= ~d;
      default: ;
    endcase
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
    model_write(a, d);
  endtask

  task automatic rd(input logic [7:0] a, input string req);
    @(negedge clk); addr = a; re = 1'b1;
    @(negedge clk); re = 1'b0;
    check(rdata === exp_read(a), req, rdata, exp_read(a));
  endtask

  task automatic chk_irq(input string req);
    @(negedge clk);
    check(irq === exp_irq(), req, {31'b0, irq}, {31'b0, exp_irq()});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] hold;
    void'($urandom(32'h5eed_0042));
    for (int b = 0; b < 3; b++) en_m[b] = '0;
    spare_m = '0;
    src = {96{1'b1}};
    repeat (3) @(negedge clk);
    // R1 reset values
    check(irq === 1'b0, "R1 irq", {31'b0, irq}, 32'h0);
    check(rdata === 32'h0, "R1 rd_data", rdata, 32'h0);
    rst_n = 1'b1;
    rd(8'h18, "R1 bank0 mask");
    rd(8'h10, "R1 bank1 mask");
    rd(8'h14, "R1 bank2 mask");
    rd(8'h0C, "R1 scratch");
    chk_irq("R1 irq after reset");

    // R3 set, R2 pending, R8 irq
    wr(8'h18, 32'h0000_00F1); rd(8'h00, "R2 R3 bank0 pending");
    chk_irq("R8 irq high");
    wr(8'h10, 32'h8000_0100); rd(8'h04, "R2 R3 bank1 pending");
    wr(8'h14, 32'h0001_0000); rd(8'h08, "R2 R3 bank2 pending");
    wr(8'h18, 32'h0000_0100); rd(8'h18, "R3 zeros keep bits");
    // R4 clear and R5 readback
    wr(8'h24, 32'h0000_0001); rd(8'h24, "R4 R5 bank0 clear addr");
    rd(8'h18, "R5 bank0 set addr");
    wr(8'h1C, 32'h8000_0000); rd(8'h1C, "R4 bank1 clear");
    wr(8'h20, 32'h0000_0000); rd(8'h14, "R4 zero clear keeps");
    // R6 writes to pending ignored
    wr(8'h00, 32'hFFFF_FFFF); wr(8'h04, 32'hFFFF_FFFF); wr(8'h08, 32'h0);
    rd(8'h18, "R6 bank0 mask"); rd(8'h10, "R6 bank1 mask"); rd(8'h14, "R6 bank2 mask");
    // R7 scratch
    wr(8'h0C, 32'hDEAD_BEEF); rd(8'h0C, "R7 scratch readback");
    rd(8'h24, "R7 mask unchanged"); chk_irq("R7 irq unchanged");
    // R9 unmapped, low address bits ignored, hold
    wr(8'h3C, 32'hFFFF_FFFF); rd(8'h3C, "R9 unmapped read");
    rd(8'h1B, "R9 low bits ignored");
    hold = rdata;
    wr(8'h18, 32'h0F0F_0000);
    repeat (2) @(negedge clk);
    check(rdata === hold, "R9 hold without read", rdata, hold);
    // R10 clear all
    wr(8'h1C, '1); wr(8'h20, '1); wr(8'h24, '1);
    chk_irq("R10 irq low");
    rd(8'h00, "R10 pend0"); rd(8'h04, "R10 pend1"); rd(8'h08, "R10 pend2");

    // random phase
    for (int i = 0; i < 600; i++) begin
      int op;
      logic [7:0] a;
      op = int'($urandom % 3);
      a  = {2'b00, 6'($urandom % 12)} << 2 | 8'($urandom % 4);
      if (op == 0) begin
        wr(a, $urandom & $urandom & $urandom);
        chk_irq("R8 random irq after write");
      end else if (op == 1) begin
        rd(a, "R2 R5 random read");
      end else begin
        @(negedge clk);
        src = {$urandom & $urandom, $urandom & $urandom, $urandom & $urandom};
        chk_irq("R8 random irq after input change");
      end
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule